// File: doc/BRIEF.md
# Low-Frequency RFID Reader Carrier Sequencer

This block is the digital control core of a low-frequency RFID reader front end. It is clocked by the recovered carrier, nominally 125 kHz and anywhere from 100 to 150 kHz. It decides when the two bridge antenna drivers may run. It freezes the oscillator and demodulator operating point around on-off keyed field gaps. It tells the host controller, through a ready/clock enable, when the receive path has settled and the carrier may be forwarded as a reference clock.

Three inputs are asynchronous: a sleep request, a modulation request and a short-circuit flag. Each passes through a two-stage synchroniser. A PLL lock flag arrives already in the carrier domain. Lowering sleep starts a settling interval counted in carrier cycles. If the PLL has not locked by a later cycle limit, a lock-timeout status is raised. A detected short turns the drivers and the ready/clock enable off, and they stay off until the host sleeps the block again. A static mode pin picks between bridge drive and single-ended drive. In single-ended drive the second driver is never used and only the first driver is keyed.

Top module: `carrier_seq`

## Requirements
- R1: While the synchronised sleep input is high, and during reset, ant_a_en, ant_b_en, chain_hold, rclk_en and lock_late are all low. The sleep synchroniser resets to the sleeping value.
- R2: With pll_lock high, rclk_en rises exactly 3128 carrier edges after sleep_req is lowered: 2 synchroniser edges, 1 entry edge and SETTLE_CYC = 3125 settling cycles. The drivers turn on 3 edges after sleep_req falls.
- R3: If pll_lock is low when settling completes, rclk_en stays low. It rises on the first edge at which pll_lock is sampled high.
- R4: lock_late rises 4378 edges after sleep_req falls if lock has not been seen (TIMEOUT_CYC = 4375). It stays high while awake, even after lock arrives, and clears on the second edge of the sleep state.
- R5: In bridge mode (one_sided = 0), both ant_a_en and ant_b_en go low 2 edges after mod_req rises. They return high 2 edges after mod_req falls.
- R6: chain_hold goes high together with the gap. It stays high until 43 edges after mod_req falls, which is RELEASE_CYC = 41 carrier cycles after the drivers re-enable.
- R7: If mod_req rises again during the release delay, the delay restarts. chain_hold then falls 43 edges after the final fall of mod_req.
- R8: rclk_en is not affected by mod_req.
- R9: With one_sided = 1, ant_b_en is always low. ant_a_en is keyed by mod_req as in R5, and rclk_en keeps running during gaps.
- R10: A short_det pulse while awake forces the drivers and rclk_en low 3 edges after it rises. This state persists after short_det clears and ends only through a sleep cycle.
- R11: short_det while sleeping has no effect on the next wake-up: rclk_en and both drivers come up normally.
- R12: Raising sleep_req while running drops every output low 3 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered carrier clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep request, asynchronous |
| mod_req | input | 1 | Field gap request, asynchronous |
| short_det | input | 1 | Antenna DC short flag, asynchronous |
| pll_lock | input | 1 | PLL lock, carrier domain |
| one_sided | input | 1 | 1 = single-ended drive, 0 = bridge |
| ant_a_en | output | 1 | First antenna driver enable |
| ant_b_en | output | 1 | Second antenna driver enable |
| chain_hold | output | 1 | Freeze oscillator/demodulator operating point |
| rclk_en | output | 1 | Forward carrier to host as ready/clock |
| lock_late | output | 1 | Lock not reached within timeout |

## Verification
Gap behaviour is swept over pulse lengths of 2 to 9 cycles. This confirms that the release delay is measured from the falling edge and not from the rising one. A gap that is re-triggered mid-release tells a restarting counter apart from one that keeps running down. Wake-up is tried three ways: with lock already present, with lock arriving late but before the timeout, and with lock arriving after the timeout. These separate the lock gate from the settle count and the sticky status. Shorts are injected while running, while settling and while asleep, which separates latch-off from the asleep case where the short is ignored.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [1:0] {
    CS_SLEEP  = 2'd0,
    CS_SETTLE = 2'd1,
    CS_RUN    = 2'd2,
    CS_FAULT  = 2'd3
  } cs_state_e;
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cs_phase.sv
module cs_phase
  import cs_pkg::*;
#(
  parameter int SETTLE_CYC  = 3125,
  parameter int TIMEOUT_CYC = 4375
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_s,
  input  logic      short_s,
  input  logic      lock,
  output cs_state_e state_o,
  output logic      late_o
);
  localparam int CW = $clog2(TIMEOUT_CYC);
  localparam logic [CW-1:0] SET_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] TO_LAST  = CW'(TIMEOUT_CYC - 1);

  cs_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          late_q, late_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    late_d  = late_q;
    case (state_q)
      CS_SLEEP: begin
        cnt_d  = '0;
        late_d = 1'b0;
        if (!sleep_s) state_d = CS_SETTLE;
      end
      CS_SETTLE: begin
        if (cnt_q != TO_LAST) cnt_d = cnt_q + 1'b1;
        if (sleep_s)                          state_d = CS_SLEEP;
        else if (short_s)                     state_d = CS_FAULT;
        else if ((cnt_q >= SET_LAST) && lock) state_d = CS_RUN;
        else if (cnt_q == TO_LAST)            late_d  = 1'b1;
      end
      CS_RUN: begin
        if (sleep_s)      state_d = CS_SLEEP;
        else if (short_s) state_d = CS_FAULT;
      end
      CS_FAULT: begin
        if (sleep_s) state_d = CS_SLEEP;
      end
      default: state_d = CS_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_SLEEP;
      cnt_q   <= '0;
      late_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      late_q  <= late_d;
    end
  end

  assign state_o = state_q;
  assign late_o  = late_q;
endmodule

// File: rtl/cs_gap.sv
module cs_gap #(
  parameter int RELEASE_CYC = 41
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic mod_s,
  output logic hold_o
);
  localparam int RW = $clog2(RELEASE_CYC + 1);
  localparam logic [RW-1:0] RLOAD = RW'(RELEASE_CYC);

  logic [RW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = !active || mod_s || (cnt_q != '0);

  always_comb begin
    if (!active)             cnt_d = '0;
    else if (mod_s)          cnt_d = RLOAD;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hold_o = active && (mod_s || (cnt_q != '0));
endmodule

// File: rtl/carrier_seq.sv
module carrier_seq
  import cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 3125,
  parameter int TIMEOUT_CYC = 4375,
  parameter int RELEASE_CYC = 41
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic mod_req,
  input  logic short_det,
  input  logic pll_lock,
  input  logic one_sided,
  output logic ant_a_en,
  output logic ant_b_en,
  output logic chain_hold,
  output logic rclk_en,
  output logic lock_late
);
  localparam int NSYNC = 3;

  logic [1:0]       rst_pipe;
  logic             rst_l;
  logic [NSYNC-1:0] async_in, sync_out;
  logic             sleep_s, mod_s, short_s;
  cs_state_e        state;
  logic             field_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_l = rst_pipe[1];

  assign async_in = {short_det, mod_req, sleep_req};

  cs_sync #(
    .W      (NSYNC),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b001)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_l),
    .d    (async_in),
    .q    (sync_out)
  );

  assign sleep_s = sync_out[0];
  assign mod_s   = sync_out[1];
  assign short_s = sync_out[2];

  cs_phase #(
    .SETTLE_CYC (SETTLE_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_phase (
    .clk    (clk),
    .rst_n  (rst_l),
    .sleep_s(sleep_s),
    .short_s(short_s),
    .lock   (pll_lock),
    .state_o(state),
    .late_o (lock_late)
  );

  assign field_on = (state == CS_SETTLE) || (state == CS_RUN);

  cs_gap #(
    .RELEASE_CYC(RELEASE_CYC)
  ) u_gap (
    .clk   (clk),
    .rst_n (rst_l),
    .active(field_on),
    .mod_s (mod_s),
    .hold_o(chain_hold)
  );

  assign ant_a_en = field_on && !mod_s;
  assign ant_b_en = field_on && !mod_s && !one_sided;
  assign rclk_en  = (state == CS_RUN);
endmodule

// File: rtl/cs_chk.sv
module cs_chk (
  input logic clk,
  input logic rst_l,
  input logic sleep_s,
  input logic mod_s,
  input logic short_s,
  input logic pll_lock,
  input logic one_sided,
  input logic ant_a_en,
  input logic ant_b_en,
  input logic chain_hold,
  input logic rclk_en,
  input logic lock_late
);
  // R1
  a_r1_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_l)
    $past(sleep_s) |-> (!ant_a_en && !ant_b_en && !rclk_en && !chain_hold));

  // R3
  a_r3_ready_needs_lock: assert property (@(posedge clk) disable iff (!rst_l)
    $rose(rclk_en) |-> $past(pll_lock));

  // R4
  a_r4_late_sticky: assert property (@(posedge clk) disable iff (!rst_l)
    (lock_late && !sleep_s && !$past(sleep_s)) |=> lock_late);

  // R6
  a_r6_hold_lingers: assert property (@(posedge clk) disable iff (!rst_l)
    ($fell(mod_s) && rclk_en && $past(rclk_en)) |-> chain_hold);

  // R9
  a_r9_b_unused: assert property (@(posedge clk) disable iff (!rst_l)
    one_sided |-> !ant_b_en);

  // R10
  a_r10_short_trips: assert property (@(posedge clk) disable iff (!rst_l)
    ($past(short_s) && $past(rclk_en) && !$past(sleep_s)) |-> (!rclk_en && !ant_a_en));
endmodule

bind carrier_seq cs_chk u_chk (
  .clk       (clk),
  .rst_l     (rst_l),
  .sleep_s   (sleep_s),
  .mod_s     (mod_s),
  .short_s   (short_s),
  .pll_lock  (pll_lock),
  .one_sided (one_sided),
  .ant_a_en  (ant_a_en),
  .ant_b_en  (ant_b_en),
  .chain_hold(chain_hold),
  .rclk_en   (rclk_en),
  .lock_late (lock_late)
);

// File: tb/sim_carrier_seq.sv
`timescale 1ns/1ps
module sim_carrier_seq;
  localparam int SETTLE  = 3125;
  localparam int TIMEOUT = 4375;
  localparam int REL     = 41;
  localparam int WAKE    = SETTLE + 3;
  localparam int LATE    = TIMEOUT + 3;
  localparam int FREE    = REL + 2;

  logic clk = 1'b0;
  logic rst_n, sleep_req, mod_req, short_det, pll_lock, one_sided;
  logic ant_a_en, ant_b_en, chain_hold, rclk_en, lock_late;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #10 clk = ~clk;

  carrier_seq u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .mod_req(mod_req),
    .short_det(short_det), .pll_lock(pll_lock), .one_sided(one_sided),
    .ant_a_en(ant_a_en), .ant_b_en(ant_b_en), .chain_hold(chain_hold),
    .rclk_en(rclk_en), .lock_late(lock_late)
  );

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic quiet(input string req);
    chk(req, ant_a_en, 1'b0);
    chk(req, ant_b_en, 1'b0);
    chk(req, chain_hold, 1'b0);
    chk(req, rclk_en, 1'b0);
  endtask

  task automatic wake_full();
    sleep_req = 1'b1; adv(4);
    sleep_req = 1'b0; adv(WAKE);
  endtask

  initial begin
    rst_n = 1'b0; sleep_req = 1'b1; mod_req = 1'b0; short_det = 1'b0;
    pll_lock = 1'b0; one_sided = 1'b0;
    adv(2);
    quiet("R1 reset");
    chk("R1 reset late", lock_late, 1'b0);
    rst_n = 1'b1; adv(5);
    quiet("R1 asleep");

    // R2 wake with lock present
    pll_lock = 1'b1; sleep_req = 1'b0;
    adv(2); chk("R2 drivers not yet", ant_a_en, 1'b0);
    adv(1); chk("R2 drivers on", ant_a_en, 1'b1); chk("R2 drv b on", ant_b_en, 1'b1);
    chk("R2 rclk low settling", rclk_en, 1'b0);
    adv(WAKE - 4); chk("R2 rclk one before", rclk_en, 1'b0);
    adv(1); chk("R2 rclk rises", rclk_en, 1'b1);
    chk("R2 no late", lock_late, 1'b0);

    // R5 R6 R8 single gap
    mod_req = 1'b1; adv(1); chk("R5 still driving", ant_a_en, 1'b1);
    adv(1); chk("R5 a off", ant_a_en, 1'b0); chk("R5 b off", ant_b_en, 1'b0);
    chk("R6 hold on", chain_hold, 1'b1); chk("R8 rclk in gap", rclk_en, 1'b1);
    adv(10); mod_req = 1'b0;
    adv(2); chk("R5 a back", ant_a_en, 1'b1); chk("R5 b back", ant_b_en, 1'b1);
    chk("R6 hold kept", chain_hold, 1'b1);
    adv(FREE - 3); chk("R6 hold last", chain_hold, 1'b1);
    adv(1); chk("R6 hold free", chain_hold, 1'b0);

    // R6 sweep over gap lengths
    for (int len = 2; len <= 9; len++) begin
      mod_req = 1'b1; adv(2);
      chk("R5 sweep a off", ant_a_en, 1'b0);
      chk("R8 sweep rclk", rclk_en, 1'b1);
      adv(len - 2); mod_req = 1'b0;
      adv(FREE - 1); chk("R6 sweep held", chain_hold, 1'b1);
      adv(1); chk("R6 sweep freed", chain_hold, 1'b0);
    end

    // R7 retrigger during release
    mod_req = 1'b1; adv(5); mod_req = 1'b0;
    adv(20); chk("R7 mid release", chain_hold, 1'b1);
    mod_req = 1'b1; adv(3); mod_req = 1'b0;
    adv(FREE - 1); chk("R7 restarted", chain_hold, 1'b1);
    adv(1); chk("R7 free", chain_hold, 1'b0);

    // R9 single-ended
    one_sided = 1'b1; adv(1);
    chk("R9 b idle", ant_b_en, 1'b0); chk("R9 a on", ant_a_en, 1'b1);
    mod_req = 1'b1; adv(2);
    chk("R9 a keyed", ant_a_en, 1'b0); chk("R9 rclk runs", rclk_en, 1'b1);
    mod_req = 1'b0; adv(2); chk("R9 a back", ant_a_en, 1'b1); chk("R9 b still", ant_b_en, 1'b0);
    adv(FREE); one_sided = 1'b0; adv(1);

    // R12 sleep while running
    sleep_req = 1'b1; adv(2); chk("R12 before", rclk_en, 1'b1);
    adv(1); quiet("R12 asleep");

    // R3 late lock before timeout
    pll_lock = 1'b0; sleep_req = 1'b0;
    adv(WAKE); chk("R3 waits for lock", rclk_en, 1'b0);
    chk("R3 drivers on", ant_a_en, 1'b1);
    pll_lock = 1'b1; adv(1); chk("R3 lock seen", rclk_en, 1'b1);
    chk("R3 no late", lock_late, 1'b0);

    // R4 timeout
    sleep_req = 1'b1; adv(4); pll_lock = 1'b0; sleep_req = 1'b0;
    adv(LATE - 1); chk("R4 not yet", lock_late, 1'b0);
    adv(1); chk("R4 late", lock_late, 1'b1); chk("R4 rclk low", rclk_en, 1'b0);
    pll_lock = 1'b1; adv(1); chk("R4 run after", rclk_en, 1'b1);
    chk("R4 sticky", lock_late, 1'b1);
    sleep_req = 1'b1; adv(3); chk("R4 held in entry", lock_late, 1'b1);
    adv(1); chk("R4 cleared", lock_late, 1'b0);

    // R10 short while running
    sleep_req = 1'b0; adv(WAKE); chk("R10 running", rclk_en, 1'b1);
    short_det = 1'b1; adv(2); chk("R10 not yet", ant_a_en, 1'b1);
    adv(1); chk("R10 a off", ant_a_en, 1'b0); chk("R10 rclk off", rclk_en, 1'b0);
    chk("R10 b off", ant_b_en, 1'b0);
    short_det = 1'b0; adv(20);
    chk("R10 latched", rclk_en, 1'b0); chk("R10 latched a", ant_a_en, 1'b0);
    wake_full(); chk("R10 recovered", rclk_en, 1'b1);

    // R10 short while settling
    sleep_req = 1'b1; adv(4); sleep_req = 1'b0; adv(100);
    short_det = 1'b1; adv(3); chk("R10 settle trip", ant_a_en, 1'b0);
    short_det = 1'b0; adv(WAKE); chk("R10 settle latched", rclk_en, 1'b0);

    // R11 short while asleep
    sleep_req = 1'b1; adv(4);
    short_det = 1'b1; adv(5); short_det = 1'b0; adv(3);
    quiet("R11 asleep");
    sleep_req = 1'b0; adv(WAKE);
    chk("R11 rclk", rclk_en, 1'b1); chk("R11 a", ant_a_en, 1'b1); chk("R11 b", ant_b_en, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule